// File: doc/BRIEF.md
# JTAG Scan Shift Engine

This block is the pin-level master for a JTAG scan. It shifts a sequence of any length out on TDI and TMS while it generates TCK, and it can store TDO as it goes. Software fills two byte-wide transmit buffers, one with the TDI stream and one with the TMS stream. It then pulses `start` with a bit count, a clock divider value and a capture flag. When the capture flag is clear, the engine leaves the receive buffer alone, so a write-only scan does no read work.

Bit k of a transfer comes from byte k/8, bit position k mod 8, of each transmit buffer. Bytes are taken in ascending address order and each byte is sent least significant bit first. Captured TDO bits are packed into the receive buffer in the same order. TCK rests low. TDI and TMS change only while TCK is low. TDO is sampled as TCK rises. A clock floor derived from the system clock frequency keeps TCK at or below the 20 MHz ceiling, whatever divider value is programmed.

Top module: `jtag_shift_engine`

## Requirements
- R1: After reset, `tck`, `tdi`, `tms`, `busy` and `done` are 0 and every receive buffer byte reads 0.
- R2: A transfer of N bits produces exactly N rising edges of `tck`. At the k-th rising edge (k from 0), `tdi` equals bit k%8 of TDI buffer byte k/8 and `tms` equals bit k%8 of TMS buffer byte k/8.
- R3: `tdi` and `tms` change only while `tck` is low: at a falling edge, or at start before the first rise. They hold steady while `tck` is high.
- R4: With `capture_en`=1, the `tdo` value present at the k-th rising edge is stored in receive byte k/8, bit k%8. The bits of the last byte at or above position N%8 (when N%8 is not 0) read 0.
- R5: With `capture_en`=0, no receive buffer byte changes.
- R6: Each TCK half period, including the low phase before the first rise, lasts H = max(`div`+1, MIN_HALF) system clocks. MIN_HALF = ceil(CLK_HZ / (2*TCK_MAX_HZ)), which is 7 at the defaults of 250 MHz and 20 MHz.
- R7: `done` is high for exactly one cycle. It is the cycle in which `tck` has just returned low for the last time, and in that cycle `busy` is already 0. Whenever `busy` is 0, `tck` is low.
- R8: A `start` pulse while `busy` is 1 is ignored. The bit count, capture flag and divider of the running transfer are kept.
- R9: A `start` with `bit_len`=0 produces a single `done` pulse and no `tck` edge.
- R10: Any `bit_len` from 1 to MAX_BITS (512 by default) is shifted completely, including lengths that are not a multiple of 8, such as 271.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a transmit buffer byte |
| wr_sel | input | 1 | Buffer select: 0 = TDI stream, 1 = TMS stream |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | AW | Receive buffer byte address |
| rd_data | output | 8 | Receive buffer byte at `rd_addr` (combinational) |
| start | input | 1 | One-cycle request to begin a transfer |
| bit_len | input | LW | Number of bits in the transfer |
| capture_en | input | 1 | Store TDO into the receive buffer |
| div | input | DIV_W | Half-period divider, H = div+1 before the floor |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| tck | output | 1 | JTAG test clock |
| tdi | output | 1 | JTAG data toward the target |
| tms | output | 1 | JTAG mode select |
| tdo | input | 1 | JTAG data from the target |

## Verification
The assertions assume three things about the inputs:
- `start` is a single-cycle pulse.
- `bit_len` never exceeds MAX_BITS.
- The transmit buffers are not rewritten while a transfer runs.

The bench respects all three. It pulses `start` for exactly one cycle and uses lengths from 0 to 512. It rewrites both buffers only between transfers.

The target is a small feedback shift register that is clocked by `tck`. It updates `tdo` on falling edges only, as a real TAP does, so the value the engine must capture is well defined at each rise.

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine #(
  parameter int MAX_BITS   = 512,
  parameter int DIV_W      = 8,
  parameter int CLK_HZ     = 250_000_000,
  parameter int TCK_MAX_HZ = 20_000_000,
  localparam int NBYTES    = (MAX_BITS + 7) / 8,
  localparam int AW        = $clog2(NBYTES),
  localparam int LW        = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             start,
  input  logic [LW-1:0]    bit_len,
  input  logic             capture_en,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done,
  output logic             tck,
  output logic             tdi,
  output logic             tms,
  input  logic             tdo
);
  localparam int MIN_HALF = (CLK_HZ + 2*TCK_MAX_HZ - 1) / (2*TCK_MAX_HZ);
  localparam logic [DIV_W-1:0] MIN_LOAD = DIV_W'(MIN_HALF - 1);

  logic [7:0] tdi_mem [NBYTES];
  logic [7:0] tms_mem [NBYTES];
  logic [7:0] cap_mem [NBYTES];

  logic [LW-1:0]    idx, len_q;
  logic [DIV_W-1:0] cnt, hload;
  logic             cap_q;

  wire [DIV_W-1:0] half_load = (div < MIN_LOAD) ? MIN_LOAD : div;
  wire [LW-1:0]    nidx      = idx + LW'(1);
  wire             tick      = busy && (cnt == '0);
  wire             sample    = tick && !tck && cap_q;
  wire             last_bit  = (idx == len_q - LW'(1));

  assign rd_data = cap_mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_sel) tms_mem[wr_addr] <= wr_data;
      else        tdi_mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cap_mem[i] <= '0;
    end else if (sample) begin
      if (idx[2:0] == 3'd0) cap_mem[idx[AW+2:3]] <= {7'b0, tdo};
      else                  cap_mem[idx[AW+2:3]][idx[2:0]] <= tdo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      tck   <= 1'b0;
      tdi   <= 1'b0;
      tms   <= 1'b0;
      idx   <= '0;
      len_q <= '0;
      cnt   <= '0;
      hload <= '0;
      cap_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        tck <= 1'b0;
        if (start) begin
          if (bit_len == '0) begin
            done <= 1'b1;
          end else begin
            busy  <= 1'b1;
            idx   <= '0;
            len_q <= bit_len;
            cap_q <= capture_en;
            cnt   <= half_load;
            hload <= half_load;
            tdi   <= tdi_mem[0][0];
            tms   <= tms_mem[0][0];
          end
        end
      end else if (cnt != '0) begin
        cnt <= cnt - DIV_W'(1);
      end else begin
        cnt <= hload;
        if (!tck) begin
          tck <= 1'b1;
        end else begin
          tck <= 1'b0;
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= nidx;
            tdi <= tdi_mem[nidx[AW+2:3]][nidx[2:0]];
            tms <= tms_mem[nidx[AW+2:3]][nidx[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/jtag_shift_engine_chk.sv
module jtag_shift_engine_chk #(
  parameter int MIN_HALF = 7,
  parameter int LW       = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tck,
  input logic          tdi,
  input logic          tms,
  input logic          busy,
  input logic          done,
  input logic          start,
  input logic [LW-1:0] len_q
);
  localparam int HW = $clog2(MIN_HALF + 1) + 1;

  logic          tck_q;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q <= 1'b0;
      hcnt  <= HW'(MIN_HALF);
    end else begin
      tck_q <= tck;
      if (tck != tck_q)               hcnt <= HW'(1);
      else if (hcnt < HW'(MIN_HALF))  hcnt <= hcnt + HW'(1);
    end
  end

  a_r3_pins_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && tck_q) |-> ($stable(tdi) && $stable(tms)));

  a_r6_min_half: assert property (@(posedge clk) disable iff (!rst_n)
    (tck != tck_q) |-> (hcnt >= HW'(MIN_HALF)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  a_r7_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r2_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> busy);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q));
endmodule

bind jtag_shift_engine jtag_shift_engine_chk #(.MIN_HALF(MIN_HALF), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tck(tck), .tdi(tdi), .tms(tms),
  .busy(busy), .done(done), .start(start), .len_q(len_q)
);

// File: tb/tb_jtag_shift_engine.sv
`timescale 1ns/1ps
module tb_jtag_shift_engine;
  localparam int AW = 6;
  localparam int LW = 10;
  localparam int NB = 64;
  localparam int MINH = 7;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic start = 0, capture_en = 0;
  logic [LW-1:0] bit_len = '0;
  logic [7:0] div = '0;
  logic busy, done, tck, tdi, tms;
  logic tdo = 0;

  int checks = 0, failures = 0;

  jtag_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .start(start),
    .bit_len(bit_len), .capture_en(capture_en), .div(div), .busy(busy), .done(done),
    .tck(tck), .tdi(tdi), .tms(tms), .tdo(tdo)
  );

  always #2 clk = ~clk;

  // target model: feedback shift register on tck, tdo moves on falling edges
  logic [4:0] sr = 5'b10110;
  int ecount = 0;
  logic obs_tdi [2048];
  logic obs_tms [2048];
  logic obs_tdo [2048];
  always @(posedge tck) begin
    obs_tdi[ecount % 2048] = tdi;
    obs_tms[ecount % 2048] = tms;
    obs_tdo[ecount % 2048] = tdo;
    ecount = ecount + 1;
    sr <= {tdi ^ sr[0], sr[4:1]};
  end
  always @(negedge tck) tdo <= sr[0];

  // pin monitors
  int exp_half = MINH;
  int bad_int = 0, done_cnt = 0, bad_dw = 0, bad_db = 0, cyc = 0;
  logic tprev = 0, bprev = 0, dprev = 0;
  always @(negedge clk) begin
    if (busy && !bprev) cyc = 1;
    else if (tck != tprev) begin
      if (busy || tprev) if (cyc != exp_half) bad_int = bad_int + 1;
      cyc = 1;
    end else cyc = cyc + 1;
    if (done && !dprev) done_cnt = done_cnt + 1;
    if (done && dprev) bad_dw = bad_dw + 1;
    if (done && busy) bad_db = bad_db + 1;
    tprev = tck; bprev = busy; dprev = done;
  end

  logic [7:0] tb_tdi [NB];
  logic [7:0] tb_tms [NB];
  logic [7:0] rxm [NB];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(int seed);
    for (int i = 0; i < NB; i++) begin
      tb_tdi[i] = 8'(i*37 + seed*11 + 3);
      tb_tms[i] = 8'((i*91) ^ (seed*29 + 5));
      @(negedge clk); wr_en = 1; wr_sel = 0; wr_addr = AW'(i); wr_data = tb_tdi[i];
      @(negedge clk); wr_sel = 1; wr_data = tb_tms[i];
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rx_compare(string req);
    int bad = 0, fb = -1, act = 0, exp = 0;
    for (int b = 0; b < NB; b++) begin
      @(negedge clk); rd_addr = AW'(b); #1;
      if (rd_data !== rxm[b]) begin
        bad++;
        if (fb < 0) begin fb = b; act = rd_data; exp = rxm[b]; end
      end
    end
    chk(bad == 0, req, $sformatf("rx byte %0d", fb), act, exp);
  endtask

  task automatic xfer(int len, bit cap, int dv, int seed, bit poke);
    int e0, d0, bi0, bw0, bb0, nt, nm, k0;
    load(seed);
    exp_half = (dv + 1 > MINH) ? dv + 1 : MINH;
    e0 = ecount; d0 = done_cnt; bi0 = bad_int; bw0 = bad_dw; bb0 = bad_db;
    @(negedge clk); start = 1; bit_len = LW'(len); capture_en = cap; div = 8'(dv);
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; bit_len = LW'(3); capture_en = !cap; div = 8'd0;
      @(negedge clk); start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ecount - e0 == len, len == 0 ? "R9" : "R10", "tck rising edges", ecount - e0, len);
    nt = 0; nm = 0; k0 = -1;
    for (int k = 0; k < len && k < ecount - e0; k++) begin
      if (obs_tdi[(e0+k)%2048] !== tb_tdi[k/8][k%8]) begin nt++; if (k0 < 0) k0 = k; end
      if (obs_tms[(e0+k)%2048] !== tb_tms[k/8][k%8]) begin nm++; if (k0 < 0) k0 = k; end
    end
    chk(nt == 0, "R2", $sformatf("tdi bit mismatches from bit %0d", k0), nt, 0);
    chk(nm == 0, "R2", $sformatf("tms bit mismatches from bit %0d", k0), nm, 0);
    chk(bad_int == bi0, "R6", $sformatf("half periods off %0d", exp_half), bad_int - bi0, 0);
    chk(done_cnt - d0 == 1, poke ? "R8" : "R7", "done pulses", done_cnt - d0, 1);
    chk(bad_dw == bw0 && bad_db == bb0, "R7", "done wide or with busy", bad_dw - bw0 + bad_db - bb0, 0);
    chk(!tck && !busy, "R7", "idle tck/busy", {tck, busy}, 0);
    if (cap) begin
      for (int b = 0; b < (len + 7) / 8; b++) begin
        logic [7:0] v = '0;
        for (int j = 0; j < 8; j++)
          if (b*8 + j < len) v[j] = obs_tdo[(e0 + b*8 + j) % 2048];
        rxm[b] = v;
      end
    end
    rx_compare(cap ? "R4" : "R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) rxm[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({tck, tdi, tms, busy, done} == 5'b0, "R1", "pins after reset", {tck, tdi, tms, busy, done}, 0);
    rx_compare("R1");
    // sweep lengths, alternating capture
    for (int n = 1; n <= 40; n++) xfer(n, (n % 3) != 0, 0, n, 0);
    xfer(0, 1, 0, 5, 0);                // R9
    xfer(271, 1, 0, 77, 0);             // R10 example length
    xfer(271, 0, 2, 78, 0);             // R5 write-only, R6 floor
    xfer(20, 1, 6, 9, 0);               // R6 div+1 == floor
    xfer(20, 1, 7, 10, 0);              // R6 above floor
    xfer(13, 1, 12, 11, 0);             // R6
    xfer(30, 1, 0, 12, 1);              // R8 start while busy
    xfer(30, 0, 1, 13, 1);              // R8 with capture flipped
    xfer(512, 1, 0, 14, 0);             // R10 full buffer
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule